// File: doc/BRIEF.md
# Per-Channel Output High-Impedance Controller

This block controls one serial output stream in a time-division multiplexed switch. For every channel time of that stream, it sets an external high-impedance control line and the tristate enable of the stream's data pin. The value for each channel comes from a per-channel bitmap. A frame pulse marks the start of channel 0. A bit-clock enable advances the bit position, and eight bit times make one channel. A rate code selects 32, 64, 128 or 256 channels per frame.

Three conditions gate the per-channel control:
- an external drive-enable pin,
- an output-enable bit from a control register,
- the active-low reset.

If any of them is inactive, the control line goes high and the data pin is tristated. When all of them are satisfied again, per-channel control starts only at the next frame pulse, never partway through a frame. The bitmap and the rate code are captured at each frame pulse. A host can therefore rewrite them during a frame without disturbing the channels that are still to be sent. A chip with sixteen such output streams uses one instance per stream.

Top module: `hiz_stream_ctrl`

## Requirements
- R1: Rate code `rate_i` 0, 1, 2, 3 selects 32, 64, 128, 256 channels per frame. The channel index wraps to 0 after the last channel even if no frame pulse arrives.
- R2: A frame tick is a clock edge with `frame_i` and `bit_en_i` both high. It makes the next bit bit 0 of channel 0. Every eighth later edge with `bit_en_i` high moves to the next channel.
- R3: In normal operation, `hiz_o` equals bit c of the captured bitmap, where c is the current channel (1 = high impedance, 0 = driven). `data_oe_o` is always the inverse of `hiz_o`.
- R4: While `drive_en_i` is low, `hiz_o` is 1 and `data_oe_o` is 0, in the same cycle and without waiting for a clock edge.
- R5: While `cr_oe_i` is low, `hiz_o` is 1 and `data_oe_o` is 0, in the same cycle.
- R6: While `rst_ni` is low, `hiz_o` is 1 and `data_oe_o` is 0. After reset the captured bitmap is all ones, and normal control waits for a frame tick.
- R7: Once `drive_en_i` or `cr_oe_i` has been low, the outputs stay in the safe state until a frame tick occurs while both enables are high.
- R8: While both enables stay high, the outputs change only on clock edges where `bit_en_i` is high.
- R9: `hiz_map_i` is captured only at a frame tick. A change during a frame has no effect until the next frame tick.
- R10: `rate_i` is captured only at a frame tick. A change during a frame does not alter where the channel index wraps in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_i | input | 2 | Output stream rate code |
| frame_i | input | 1 | Frame pulse, qualified by `bit_en_i` |
| bit_en_i | input | 1 | One-cycle strobe per output bit |
| drive_en_i | input | 1 | External output-drive enable pin |
| cr_oe_i | input | 1 | Control-register output-enable bit |
| hiz_map_i | input | 256 | Staging bitmap, bit c = channel c high impedance |
| hiz_o | output | 1 | External high-impedance control line |
| data_oe_o | output | 1 | Tristate enable of the stream data pin, 1 = drive |

## Verification
The bench sweeps a full frame at every rate with a computed bitmap pattern and checks each channel. Two faults would show up here: a wrong channel length, which moves the boundaries, and a wrong wrap count, which repeats or skips channels. It also runs past the end of a frame without a frame pulse to confirm the wrap. It changes the bitmap and the rate code in mid-frame; a design that did not latch them would switch pattern or period too early. Finally, it lowers each enable and the reset in mid-frame and raises them again. A design that resumed at once would drive a partial frame instead of holding high until the next frame pulse.

// File: rtl/hiz_pkg.sv
package hiz_pkg;
  localparam int BASE_CH     = 32;
  localparam int MAX_CH      = 256;
  localparam int CH_W        = $clog2(MAX_CH);
  localparam int BITS_PER_CH = 8;
  localparam int BIT_W       = $clog2(BITS_PER_CH);
  localparam int RATE_W      = 2;

  typedef enum logic [RATE_W-1:0] {
    RATE_X1 = 2'd0,
    RATE_X2 = 2'd1,
    RATE_X4 = 2'd2,
    RATE_X8 = 2'd3
  } rate_e;

  function automatic logic [CH_W-1:0] last_ch(rate_e r);
    return CH_W'((BASE_CH << int'(r)) - 1);
  endfunction
endpackage

// File: rtl/hiz_timebase.sv
module hiz_timebase
  import hiz_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            bit_en_i,
  input  logic [CH_W-1:0] last_i,
  output logic [CH_W-1:0] ch_o
);
  logic [BIT_W-1:0] bit_q;
  logic [CH_W-1:0]  ch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      ch_q  <= '0;
    end else if (tick_i) begin
      bit_q <= '0;
      ch_q  <= '0;
    end else if (bit_en_i) begin
      if (bit_q == BIT_W'(BITS_PER_CH - 1)) begin
        bit_q <= '0;
        ch_q  <= (ch_q == last_i) ? '0 : ch_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign ch_o = ch_q;
endmodule

// File: rtl/hiz_map_buf.sv
module hiz_map_buf
  import hiz_pkg::*;
#(
  parameter int N = MAX_CH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [N-1:0]    map_i,
  input  logic [CH_W-1:0] sel_i,
  output logic            bit_o
);
  logic [N-1:0] active_q;

  // reset to all ones: every channel high impedance until first capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_q <= '1;
    else if (load_i) active_q <= map_i;
  end

  assign bit_o = active_q[sel_i];
endmodule

// File: rtl/hiz_gate.sv
module hiz_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drive_en_i,
  input  logic cr_oe_i,
  input  logic tick_i,
  input  logic map_bit_i,
  output logic hiz_o,
  output logic oe_o
);
  logic en;
  logic run_q;

  assign en = drive_en_i & cr_oe_i;

  // run only re-arms on a frame tick, never mid-frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 1'b0;
    else if (!en)    run_q <= 1'b0;
    else if (tick_i) run_q <= 1'b1;
  end

  assign hiz_o = ~(en & run_q & rst_ni) | map_bit_i;
  assign oe_o  = ~hiz_o;
endmodule

// File: rtl/hiz_stream_ctrl.sv
module hiz_stream_ctrl
  import hiz_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              frame_i,
  input  logic              bit_en_i,
  input  logic              drive_en_i,
  input  logic              cr_oe_i,
  input  logic [MAX_CH-1:0] hiz_map_i,
  output logic              hiz_o,
  output logic              data_oe_o
);
  logic            tick;
  rate_e           rate_q;
  logic [CH_W-1:0] ch;
  logic            map_bit;

  assign tick = frame_i & bit_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rate_q <= RATE_X1;
    else if (tick) rate_q <= rate_e'(rate_i);
  end

  hiz_timebase i_timebase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .bit_en_i (bit_en_i),
    .last_i   (last_ch(rate_q)),
    .ch_o     (ch)
  );

  hiz_map_buf #(.N(MAX_CH)) i_map_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tick),
    .map_i  (hiz_map_i),
    .sel_i  (ch),
    .bit_o  (map_bit)
  );

  hiz_gate i_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .drive_en_i (drive_en_i),
    .cr_oe_i    (cr_oe_i),
    .tick_i     (tick),
    .map_bit_i  (map_bit),
    .hiz_o      (hiz_o),
    .oe_o       (data_oe_o)
  );
endmodule

// File: rtl/hiz_stream_ctrl_chk.sv
module hiz_stream_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic drive_en_i,
  input logic cr_oe_i,
  input logic hiz_o,
  input logic data_oe_o
);
  always_comb begin
    if (!rst_ni) a_r6_reset_safe: assert (hiz_o && !data_oe_o);
    if (!drive_en_i) a_r4_pin_safe: assert (hiz_o && !data_oe_o);
    if (!cr_oe_i) a_r5_reg_safe: assert (hiz_o && !data_oe_o);
  end

  a_r7_hold_until_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!(drive_en_i && cr_oe_i)) |-> hiz_o);

  a_r8_edge_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(bit_en_i) && $past(drive_en_i && cr_oe_i) && drive_en_i && cr_oe_i)
      |-> $stable(hiz_o));

  a_r3_oe_inverse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !hiz_o);
endmodule

bind hiz_stream_ctrl hiz_stream_ctrl_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bit_en_i   (bit_en_i),
  .drive_en_i (drive_en_i),
  .cr_oe_i    (cr_oe_i),
  .hiz_o      (hiz_o),
  .data_oe_o  (data_oe_o)
);

// File: tb/test_hiz_stream_ctrl.sv
module test_hiz_stream_ctrl;
  localparam int NCH = 256;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [1:0]     rate_i = 2'd0;
  logic           frame_i = 1'b0;
  logic           bit_en_i = 1'b0;
  logic           drive_en_i = 1'b0;
  logic           cr_oe_i = 1'b0;
  logic [NCH-1:0] hiz_map_i = '0;
  logic           hiz_o;
  logic           data_oe_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [NCH-1:0] m_map = '1;
  int             m_nch = 32;
  int             m_k   = 0;
  logic           m_run = 1'b0;

  always #2.5 clk_i = ~clk_i;

  hiz_stream_ctrl i_hiz_stream_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rate_i     (rate_i),
    .frame_i    (frame_i),
    .bit_en_i   (bit_en_i),
    .drive_en_i (drive_en_i),
    .cr_oe_i    (cr_oe_i),
    .hiz_map_i  (hiz_map_i),
    .hiz_o      (hiz_o),
    .data_oe_o  (data_oe_o)
  );

  function automatic logic [NCH-1:0] pattern(int seed);
    logic [NCH-1:0] v;
    for (int c = 0; c < NCH; c++) v[c] = 1'(((c * seed) >> 3) ^ c ^ seed);
    return v;
  endfunction

  task automatic chk(string req, logic exp);
    n_tests++;
    if (hiz_o !== exp || data_oe_o !== !exp) begin
      n_fail++;
      $display("FAIL %s: hiz_o=%b data_oe_o=%b expected hiz_o=%b data_oe_o=%b (bit %0d)",
               req, hiz_o, data_oe_o, exp, !exp, m_k);
    end
  endtask

  function automatic logic expect_hiz();
    if (!rst_ni || !(drive_en_i && cr_oe_i) || !m_run) return 1'b1;
    return m_map[(m_k / 8) % m_nch];
  endfunction

  task automatic tick(logic fr, logic be, string req);
    frame_i  = fr;
    bit_en_i = be;
    if (!(drive_en_i && cr_oe_i)) m_run = 1'b0;
    else if (fr && be) m_run = 1'b1;
    if (fr && be) begin
      m_map = hiz_map_i;
      m_nch = 32 << rate_i;
      m_k   = 0;
    end else if (be) begin
      m_k++;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    chk(req, expect_hiz());
  endtask

  task automatic run_bits(int n, string req);
    for (int i = 0; i < n; i++) begin
      tick(1'b0, 1'b0, req);
      tick(1'b0, 1'b1, req);
    end
  endtask

  initial begin : watchdog
    #900000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    // R6 reset state
    chk("R6", 1'b1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive_en_i = 1'b1;
    cr_oe_i = 1'b1;
    hiz_map_i = '0;
    // R7: enables high but no frame yet -> stays safe
    run_bits(20, "R7");

    // R1 R2 R3 R8: full-frame sweep at every rate
    for (int r = 0; r < 4; r++) begin
      rate_i = 2'(r);
      hiz_map_i = pattern(r + 5);
      tick(1'b1, 1'b1, "R3");
      run_bits((32 << r) * 8 - 1, "R2");
    end

    // R1: wrap without frame pulse at rate 0
    rate_i = 2'd0;
    hiz_map_i = pattern(11);
    tick(1'b1, 1'b1, "R1");
    run_bits(32 * 8 + 40, "R1");

    // R9 R10: change map and rate mid-frame
    rate_i = 2'd0;
    hiz_map_i = pattern(13);
    tick(1'b1, 1'b1, "R9");
    run_bits(60, "R9");
    hiz_map_i = ~pattern(13);
    rate_i = 2'd3;
    run_bits(32 * 8 + 30, "R10");
    tick(1'b1, 1'b1, "R9");
    run_bits(64 * 8, "R10");

    // R4 R7: drive-enable pin dropped mid-frame
    rate_i = 2'd1;
    hiz_map_i = pattern(7);
    tick(1'b1, 1'b1, "R3");
    run_bits(40, "R3");
    drive_en_i = 1'b0;
    #0.5 chk("R4", 1'b1);
    run_bits(20, "R4");
    drive_en_i = 1'b1;
    run_bits(60, "R7");
    tick(1'b1, 1'b1, "R7");
    run_bits(40, "R3");

    // R5 R7: register enable dropped mid-frame
    cr_oe_i = 1'b0;
    #0.5 chk("R5", 1'b1);
    run_bits(20, "R5");
    cr_oe_i = 1'b1;
    run_bits(30, "R7");
    tick(1'b1, 1'b1, "R7");
    run_bits(40, "R3");

    // R6: reset mid-frame, map returns to all ones
    rst_ni = 1'b0;
    #0.5 chk("R6", 1'b1);
    m_run = 1'b0;
    m_map = '1;
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_bits(30, "R6");
    hiz_map_i = pattern(3);
    tick(1'b1, 1'b1, "R6");
    run_bits(64 * 8, "R3");

    // R2: frame pulse without bit enable is not a frame tick
    tick(1'b1, 1'b0, "R2");
    run_bits(20, "R2");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule